// File: doc/BRIEF.md
# HDLC Bit-Serial Receiver with Split-Buffer Interrupts

This block receives a bit-serial HDLC data link stream, one bit per cycle in which a bit strobe is high. It finds flag octets, drops the zero inserted after every run of five ones, and recognises abort runs of seven or more ones. Received octets go into a small circular buffer that is handled as two halves. A processor is interrupted each time a half fills, when a frame closes, and when a frame is aborted. A frame check sequence runs alongside reception.

The receiver cannot tell the two check octets from message octets until the closing flag arrives, so it stores them like any other octet. Software must drop the last two stored octets of each frame. If the closing flag comes straight after a half-full interrupt, a second interrupt follows with the same pointer. The processor then learns that the two octets it has just read were the check sequence.

A combined status/control word reports the pending interrupt, its cause, the buffer pointer and the check result. Reading that word clears the pending interrupt. The interrupt output is gated by an enable bit that software writes through a separate strobe.

Top module: `hdlc_rx_split_buffer`

## Requirements
- R1: After reset the status word (address 8) reads 0x0000 and irq_o is low. Back-to-back flags (octet 0x7E) raise no interrupt.
- R2: Bits arrive least significant first. A 0 that follows five consecutive 1s is removed. Each frame stores its octets from buffer index 0 upward, wrapping modulo 8. Buffer address n (0..7) returns that octet in read bits 7:0.
- R3: Writing an octet to index 3 or 7 raises a half-full event. The status word then shows bit 15 = 1, bits 2:0 = that index, and bits 4, 5 and 6 = 0.
- R4: A closing flag after at least 4 stored octets raises an end-of-frame event. The status word then shows bit 15 = 1, bit 4 = 1, bit 6 = 0, and bits 2:0 = the last index written.
- R5: A closing flag arriving with no octet after a half-full event reports the same pointer (3 or 7). With one octet after it, the pointer is 0 or 4.
- R6: Seven consecutive 1s inside a frame holding at least 4 octets raise an abort event. The status word then shows bit 15 = 1, bit 6 = 1, bits 4 and 5 = 0, and bits 2:0 = the last index. Input bits are then ignored until the next flag.
- R7: A frame or abort with fewer than 4 stored octets raises no interrupt. After an end-of-frame or abort event, no interrupt occurs until 4 octets of a new frame are stored.
- R8: Reading address 8 clears bit 15 and irq_o. The newest event overwrites the cause fields. irq_o equals bit 15 AND bit 7. A control write loads bit 7 from ctl_irq_en_i. With bit 7 at 0, events still set bit 15 but irq_o stays low.
- R9: The check sequence is CRC-16 (reflected polynomial 0x8408, preset 0xFFFF), stored in the buffer as two ordinary octets. Bit 5 of an end-of-frame status is 0 when the residue over all stored octets equals 0xF0B8, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bit_vld_i | input | 1 | Strobe: bit_i carries a line bit this cycle |
| bit_i | input | 1 | Serial line bit |
| rd_en_i | input | 1 | Read strobe; a read of address 8 clears the pending bit |
| rd_addr_i | input | 4 | 0..7 buffer octets, 8 status word |
| rd_data_o | output | 16 | Combinational read data |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_irq_en_i | input | 1 | Value written to the interrupt enable (bit 7) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default BUF_DEPTH of 8, which gives two 4-octet halves. With that depth, frames of four to nine stored octets reach both half boundaries, the wrap back to index 0, and every end-of-frame pointer case, including a repeated 3 and the straddling 0 and 4. Frames chosen with long runs of ones force zero removal inside both data and check octets. Corrupted, short and aborted frames, and a pass with the enable cleared, cover the remaining status encodings.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int REG_W = 16;
    localparam int ST_PEND = 15;
    localparam int ST_EN = 7;
    localparam int ST_ABRT = 6;
    localparam int ST_BAD = 5;
    localparam int ST_IDLE = 4;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;

    typedef struct packed {
        logic [2:0] ones;
        logic       dv;
        logic       db;
        logic       fl;
        logic       ab;
    } dfr_state_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic data_vld_o,
    output logic data_bit_o,
    output logic flag_o,
    output logic abort_o
);
    dfr_state_t q, d;

    always_comb begin
        d    = q;
        d.dv = 1'b0;
        d.fl = 1'b0;
        d.ab = 1'b0;
        d.db = bit_i;
        if (bit_vld_i) begin
            if (bit_i) begin
                if (q.ones != 3'd7) d.ones = q.ones + 3'd1;
                if (q.ones <= 3'd5) d.dv = 1'b1;
                if (q.ones == 3'd6) d.ab = 1'b1;
            end else begin
                d.ones = 3'd0;
                case (q.ones)
                    3'd5:    d.dv = 1'b0;  // stuffed zero dropped
                    3'd6:    d.fl = 1'b1;
                    3'd7:    d.dv = 1'b0;  // end of abort run
                    default: d.dv = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign data_vld_o = q.dv;
    assign data_bit_o = q.db;
    assign flag_o     = q.fl;
    assign abort_o    = q.ab;

    // R1: a flag pulse never carries a data bit or an abort
    a_r1_flag_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.fl |-> (!q.dv && !q.ab));
    // R6: an abort is only reported after a received 1
    a_r6_abort_after_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ab |-> $past(bit_vld_i && bit_i));
endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
    import hdlc_rx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output logic       good_o
);
    logic [15:0] crc_q, crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clr_i)           crc_d = CRC_PRESET;
        else if (byte_vld_i) crc_d = crc16_step(crc_q, byte_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) crc_q <= CRC_PRESET;
        else         crc_q <= crc_d;
    end

    assign good_o = (crc_q == CRC_GOOD);

    // R9: the register restarts from the preset after a flag
    a_r9_preset_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (crc_q == CRC_PRESET));
endmodule

// File: rtl/hdlc_rx_split_buffer.sv
module hdlc_rx_split_buffer
    import hdlc_rx_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    localparam int PTR_W = $clog2(BUF_DEPTH),
    localparam int ADDR_W = PTR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              ctl_wr_i,
    input  logic              ctl_irq_en_i,
    output logic              irq_o
);
    localparam int HALF = BUF_DEPTH / 2;
    localparam int HALF_W = $clog2(HALF);
    localparam int CNT_W = HALF_W + 1;
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BUF_DEPTH);

    typedef struct packed {
        logic                      in_frame;
        logic [7:0]                sr;
        logic [2:0]                bitcnt;
        logic [PTR_W-1:0]          wp;
        logic [PTR_W-1:0]          last;
        logic [PTR_W-1:0]          ptr;
        logic [CNT_W-1:0]          nbytes;
        logic                      pend;
        logic                      en;
        logic                      idle;
        logic                      bad;
        logic                      abrt;
        logic [BUF_DEPTH-1:0][7:0] mem;
    } st_t;

    st_t q, d;
    logic dfr_dv, dfr_db, dfr_fl, dfr_ab;
    logic crc_good, byte_done, half_evt, eom_evt, abt_evt, any_evt, rd_hit, crc_clr;
    logic [7:0] byte_val;

    hdlc_rx_deframer u_dfr (
        .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
        .data_vld_o(dfr_dv), .data_bit_o(dfr_db), .flag_o(dfr_fl), .abort_o(dfr_ab)
    );

    hdlc_rx_crc16 u_crc (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(crc_clr),
        .byte_vld_i(byte_done), .byte_i(byte_val), .good_o(crc_good)
    );

    always_comb begin
        d         = q;
        byte_val  = {dfr_db, q.sr[7:1]};
        byte_done = q.in_frame && dfr_dv && (q.bitcnt == 3'd7);
        half_evt  = byte_done && (&q.wp[HALF_W-1:0]);
        eom_evt   = dfr_fl && q.in_frame && (q.nbytes == HALF_CNT) && (q.bitcnt == 3'd7);
        abt_evt   = dfr_ab && q.in_frame && (q.nbytes == HALF_CNT);
        any_evt   = half_evt || eom_evt || abt_evt;
        rd_hit    = rd_en_i && (rd_addr_i == STAT_ADDR);
        crc_clr   = dfr_fl;

        if (q.in_frame && dfr_dv) begin
            d.sr     = byte_val;
            d.bitcnt = q.bitcnt + 3'd1;
        end
        if (byte_done) begin
            d.mem[q.wp] = byte_val;
            d.wp        = q.wp + PTR_W'(1);
            d.last      = q.wp;
            if (q.nbytes != HALF_CNT) d.nbytes = q.nbytes + CNT_W'(1);
        end
        if (dfr_fl) begin
            d.in_frame = 1'b1;
            d.bitcnt   = 3'd0;
            d.wp       = '0;
            d.nbytes   = '0;
        end
        if (dfr_ab) d.in_frame = 1'b0;

        if (rd_hit)   d.pend = 1'b0;
        if (ctl_wr_i) d.en = ctl_irq_en_i;

        if (half_evt) begin
            d.pend = 1'b1; d.idle = 1'b0; d.bad = 1'b0; d.abrt = 1'b0; d.ptr = q.wp;
        end
        if (eom_evt) begin
            d.pend = 1'b1; d.idle = 1'b1; d.bad = !crc_good; d.abrt = 1'b0; d.ptr = q.last;
        end
        if (abt_evt) begin
            d.pend = 1'b1; d.idle = 1'b0; d.bad = 1'b0; d.abrt = 1'b1; d.ptr = q.last;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == STAT_ADDR) begin
            rd_data_o[ST_PEND]     = q.pend;
            rd_data_o[ST_EN]       = q.en;
            rd_data_o[ST_ABRT]     = q.abrt;
            rd_data_o[ST_BAD]      = q.bad;
            rd_data_o[ST_IDLE]     = q.idle;
            rd_data_o[PTR_W-1:0]   = q.ptr;
        end else if (rd_addr_i < STAT_ADDR) begin
            rd_data_o[7:0] = q.mem[rd_addr_i[PTR_W-1:0]];
        end
    end

    assign irq_o = q.pend && q.en;

    a_r3_half_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_evt |=> (q.pend && !q.idle && (&q.ptr[HALF_W-1:0])));
    a_r4_eom_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eom_evt |=> (q.pend && q.idle && !q.abrt));
    a_r6_abort_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abt_evt |=> (q.pend && q.abrt && !q.idle));
    a_r7_short_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((dfr_fl || dfr_ab) && (q.nbytes != HALF_CNT) && !rd_hit && !ctl_wr_i) |=> $stable(irq_o));
    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hit && !any_evt) |=> !irq_o);
endmodule

// File: tb/tb_hdlc_rx_split_buffer.sv
module tb_hdlc_rx_split_buffer;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] STAT = 4'd8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, rx_bit = 1'b0;
    logic rd_en = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic [15:0] rd_data;
    logic ctl_wr = 1'b0, ctl_en = 1'b0;
    logic irq;

    int n_chk = 0, n_bad = 0;
    bit stim_done = 0, finished = 0;
    int tx_ones = 0;

    typedef struct {
        logic [15:0] stat;
        bit          has_bytes;
        logic [7:0]  b [4];
        string       tag;
    } exp_t;
    exp_t sb[$];

    hdlc_rx_split_buffer dut (
        .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(bit_vld), .bit_i(rx_bit),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ctl_wr_i(ctl_wr), .ctl_irq_en_i(ctl_en), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] v[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (v[k]) begin
            for (int j = 0; j < 8; j++) begin
                logic mix = c[0] ^ v[k][j];
                c = {1'b0, c[15:1]};
                if (mix) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; rx_bit = b;
        @(negedge clk); bit_vld = 1'b0; rx_bit = ~b;
        @(negedge clk);
    endtask

    task automatic send_data_bit(input logic b);
        send_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic send_flag();
        logic [7:0] f = 8'h7E;
        for (int j = 0; j < 8; j++) send_bit(f[j]);
        tx_ones = 0;
    endtask

    task automatic send_raw_byte(input logic [7:0] v);
        for (int j = 0; j < 8; j++) send_bit(v[j]);
    endtask

    // Pushes the expected events, then drives the frame on the line.
    task automatic send_frame(input logic [7:0] data[$], input bit corrupt, input bit do_abort);
        logic [7:0] all[$];
        logic [15:0] c;
        int n;
        all = data;
        if (!do_abort) begin
            c = ~ref_crc(data);
            if (corrupt) c[0] = ~c[0];
            all.push_back(c[7:0]);
            all.push_back(c[15:8]);
        end
        n = all.size();
        for (int k = 0; k < n; k++) begin
            if (k % 4 == 3) begin
                exp_t e;
                e.stat = 16'h8080 | 16'(k % 8);
                e.has_bytes = 1;
                for (int j = 0; j < 4; j++) e.b[j] = all[k-3+j];
                e.tag = "R3 half-full";
                sb.push_back(e);
            end
        end
        if (n >= 4) begin
            exp_t e;
            e.has_bytes = 0;
            if (do_abort) begin
                e.stat = 16'h80C0 | 16'((n-1) % 8);
                e.tag = "R6 abort";
            end else begin
                e.stat = 16'h8090 | (corrupt ? 16'h0020 : 16'h0000) | 16'((n-1) % 8);
                e.tag = ((n-1) % 4 == 3) ? "R5 repeated pointer / R4 R9 end" : "R4 R5 R9 end of frame";
            end
            sb.push_back(e);
        end
        send_flag();
        foreach (all[k]) for (int j = 0; j < 8; j++) send_data_bit(all[k][j]);
        if (do_abort) begin
            for (int j = 0; j < 8; j++) send_bit(1'b1);
            send_raw_byte(8'h00);  // junk after abort must be ignored (R6)
        end
        send_flag();
    endtask

    task automatic service();
        logic [15:0] got;
        exp_t e;
        rd_en = 1'b1; rd_addr = STAT;
        #1 got = rd_data;
        @(negedge clk);
        if (sb.size() == 0) begin
            check("R7 unexpected interrupt", got, 16'hxxxx);
        end else begin
            e = sb.pop_front();
            check(e.tag, got, e.stat);
            if (e.has_bytes) begin
                for (int j = 0; j < 4; j++) begin
                    rd_addr = {1'b0, got[2:0] - 3'd3 + 3'(j)};
                    #1 check("R2 buffer octet", rd_data, {8'h00, e.b[j]});
                    @(negedge clk);
                end
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic reg_read(output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = STAT;
        #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ctl_write(input logic en);
        @(negedge clk); ctl_wr = 1'b1; ctl_en = en;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = STAT; #1;
        check("R1 reset status", rd_data, 16'h0000);
        check("R1 reset irq", {15'd0, irq}, 16'h0000);
        ctl_write(1'b1);
        reg_read(v);
        check("R8 enable written", v, 16'h0080);

        fork
            begin
                for (int k = 0; k < 4; k++) send_flag();
                check("R1 idle flags no irq", {15'd0, irq}, 16'h0000);
                send_frame('{8'hFF, 8'h7E}, 0, 0);                    // 4 stored, ptr 3 twice
                send_frame('{8'h3E, 8'hF8, 8'h1F}, 0, 0);             // straddle, ptr 4
                send_frame('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, 0, 0); // ptr 7 twice
                send_frame('{8'hA5, 8'h5A, 8'hFF, 8'hFF, 8'h00, 8'hC3, 8'h3C}, 0, 0); // wrap, ptr 0
                send_frame('{8'h11, 8'h22, 8'h33, 8'h44}, 1, 0);      // bad check
                send_frame('{8'h99}, 0, 0);                           // short, silent (R7)
                send_frame('{8'h10, 8'h20, 8'h30, 8'h40, 8'h50}, 0, 1); // abort ptr 4
                send_frame('{8'h77, 8'h88}, 0, 1);                    // short abort, silent (R7)
                send_frame('{8'hDE, 8'hAD}, 0, 0);                    // new frame starts at 0 (R7)
                repeat (40) @(negedge clk);
                stim_done = 1;
            end
            begin
                while (!stim_done) begin
                    @(negedge clk);
                    if (irq === 1'b1) service();
                end
            end
        join
        check("R7 all expected events seen", 16'(sb.size()), 16'd0);

        ctl_write(1'b0);
        send_frame('{8'hCA, 8'hFE}, 0, 0);
        sb.delete();
        check("R8 masked irq", {15'd0, irq}, 16'h0000);
        reg_read(v);
        check("R8 masked pending latest event", v, 16'h8013);
        reg_read(v);
        check("R8 read cleared pending", v, 16'h0013);
        ctl_write(1'b1);
        check("R8 irq after clear", {15'd0, irq}, 16'h0000);
        reg_read(v);
        check("R8 enable restored", v, 16'h0093);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule